// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time for a chip: seconds, minutes, hours, day of month, month and a two-digit year, all in packed BCD. A free-running tick enable (nominally 32.768 kHz) is divided down by a prescaler so that the calendar advances once per `TICKS_PER_SEC` enabled ticks. The calendar handles month lengths and leap Februaries for the years 2000 to 2099 and counts hours in 24-hour form.

A second set of six BCD fields holds an alarm time. When the calendar steps onto a time equal to all six alarm fields, a sticky alarm flag is raised. Sticky event flags also record each second, minute, hour and day boundary. Software reaches the time, alarm, control, status and interrupt-enable registers through a byte-wide register port with combinational read data. Two interrupt outputs are provided: a one-cycle timer pulse per second and a level alarm request.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00; the run bit, all status flags and both interrupt enables read 0; both interrupt outputs are low.
- R2: Time fields are at byte offsets 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year; the alarm fields sit at 0x20 to 0x34 in the same order; a written value reads back unchanged and unmapped offsets (for example 0x18, 0x3C) read 0.
- R3: While running, the calendar advances exactly once per `TICKS_PER_SEC` tick enables; seconds and minutes roll 59 to 00 and hours 23 to 00, each carrying into the next field, with BCD digit carries (19 to 20, 09 to 10).
- R4: The day rolls to 01 after the last day of the month: 30 days for months 04, 06, 09, 11; 31 for the others; February has 29 days when the year value is divisible by 4 (00, 12, 24 are leap, 10 and 23 are not), otherwise 28.
- R5: Month 12 rolls to 01 with a carry into the year, and year 99 rolls to 00.
- R6: Control register offset 0x40 bit 0 set makes the calendar run; cleared, the time holds still. Status bit 1 reads the run state.
- R7: Status register offset 0x44 holds sticky flags: bit 2 second, bit 3 minute, bit 4 hour, bit 5 day, bit 6 alarm; each is cleared by writing 1 to its bit, writing 0 leaves it unchanged.
- R8: Interrupt enable offset 0x48 bit 2 set makes `irq_timer` pulse high for one clock cycle at each second step.
- R9: The alarm flag is set only when a second step lands on a time equal to all six alarm fields; a single differing field prevents it. `irq_alarm` is high while the alarm flag and enable bit 3 at offset 0x48 are both set.
- R10: A write to a time field loads it directly; counting continues from the loaded value at the next second step.
- R11: Status bit 0 (busy) is high while running during the last prescaler count before a second step, i.e. once per second for one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Low-frequency tick enable feeding the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| irq_timer | output | 1 | One-cycle pulse per second when enabled |
| irq_alarm | output | 1 | Level alarm interrupt request |

## Verification
The calendar is exercised with a table of start times, each run for exactly one second and compared with the expected successor time and event flags; the entries separate a plain second step, minute and hour carries, BCD digit carries, 30- and 31-day month ends, leap and non-leap Februaries chosen so that a binary rather than BCD divisibility test would fail, and the year wrap. Alarm runs distinguish a full six-field match from a match differing only in the year, and a set flag with the enable off from one with it on. Timer pulses are counted over a fixed span to show the one-second rate, and the stopped case shows the time frozen.

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int AW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq_timer,
  output logic          irq_alarm
);

  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);
  localparam int NF = 6;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h40);
  localparam logic [AW-1:0] A_STS  = AW'(8'h44);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h48);

  logic [PW-1:0] presc;
  logic [7:0]    t_q  [NF];
  logic [7:0]    al_q [NF];
  logic [7:0]    nx   [NF];
  logic          run_q, ie_tmr, ie_alm, irq_tmr_q;
  logic [4:0]    flags_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    yb = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  wire sec_stb = run_q & tick_en & (presc == PRE_LAST);
  wire busy    = run_q & (presc == PRE_LAST);

  wire [2:0] idx      = bus_addr[4:2];
  wire       in_time  = (bus_addr[AW-1:5] == '0) && (bus_addr[1:0] == 2'b00) && (idx < 3'd6);
  wire       in_alarm = (bus_addr[AW-1:5] == (AW-5)'(1)) && (bus_addr[1:0] == 2'b00) && (idx < 3'd6);

  wire sec_wrap = (t_q[0] == 8'h59);
  wire min_wrap = sec_wrap && (t_q[1] == 8'h59);
  wire hr_wrap  = min_wrap && (t_q[2] == 8'h23);
  wire day_wrap = hr_wrap  && (t_q[3] == month_len(t_q[4], t_q[5]));
  wire mon_wrap = day_wrap && (t_q[4] == 8'h12);

  always_comb begin
    nx[0] = sec_wrap ? 8'h00 : bcd_inc(t_q[0]);
    nx[1] = sec_wrap ? ((t_q[1] == 8'h59) ? 8'h00 : bcd_inc(t_q[1])) : t_q[1];
    nx[2] = min_wrap ? ((t_q[2] == 8'h23) ? 8'h00 : bcd_inc(t_q[2])) : t_q[2];
    nx[3] = hr_wrap  ? (day_wrap ? 8'h01 : bcd_inc(t_q[3])) : t_q[3];
    nx[4] = day_wrap ? (mon_wrap ? 8'h01 : bcd_inc(t_q[4])) : t_q[4];
    nx[5] = mon_wrap ? ((t_q[5] == 8'h99) ? 8'h00 : bcd_inc(t_q[5])) : t_q[5];
  end

  logic alm_match;
  always_comb begin
    alm_match = 1'b1;
    for (int i = 0; i < NF; i++)
      if (nx[i] != al_q[i]) alm_match = 1'b0;
  end

  wire [4:0] ev_set = {sec_stb & alm_match, sec_stb & hr_wrap, sec_stb & min_wrap,
                       sec_stb & sec_wrap, sec_stb};
  wire [4:0] ev_clr = (bus_wr && bus_addr == A_STS) ? bus_wdata[6:2] : 5'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc <= '0;
    else if (!run_q) presc <= '0;
    else if (tick_en) presc <= (presc == PRE_LAST) ? '0 : presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        t_q[i]  <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        al_q[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
      end
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (bus_wr && in_time && idx == 3'(i)) t_q[i] <= bus_wdata;
        else if (sec_stb) t_q[i] <= nx[i];
        if (bus_wr && in_alarm && idx == 3'(i)) al_q[i] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ie_tmr    <= 1'b0;
      ie_alm    <= 1'b0;
      flags_q   <= '0;
      irq_tmr_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) run_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_IEN) begin
        ie_tmr <= bus_wdata[2];
        ie_alm <= bus_wdata[3];
      end
      flags_q   <= (flags_q & ~ev_clr) | ev_set;
      irq_tmr_q <= sec_stb & ie_tmr;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (in_time)                bus_rdata = t_q[idx];
    else if (in_alarm)          bus_rdata = al_q[idx];
    else if (bus_addr == A_CTRL) bus_rdata = {7'd0, run_q};
    else if (bus_addr == A_STS)  bus_rdata = {1'b0, flags_q, run_q, busy};
    else if (bus_addr == A_IEN)  bus_rdata = {4'd0, ie_alm, ie_tmr, 2'd0};
  end

  assign irq_timer = irq_tmr_q;
  assign irq_alarm = flags_q[4] & ie_alm;

endmodule

// File: rtl/rtc_checks.sv
module rtc_checks #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_stb,
  input logic          run,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    sec,
  input logic          flag_alarm,
  input logic          irq_timer
);

  wire alarm_clr = bus_wr && (bus_addr == AW'(8'h44)) && bus_wdata[6];

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && sec == 8'h59 && !bus_wr) |=> (sec == 8'h00));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(sec));

  assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_alarm && !alarm_clr) |=> flag_alarm);

  assert_timer_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |-> $past(sec_stb));

  assert_alarm_on_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_alarm) |-> $past(sec_stb));

endmodule

bind bcd_calendar_rtc rtc_checks #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_stb(sec_stb), .run(run_q),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sec(t_q[0]), .flag_alarm(flags_q[4]), .irq_timer(irq_timer)
);

// File: tb/sim_bcd_calendar_rtc.sv
`timescale 1ns/1ps
module sim_bcd_calendar_rtc;

  localparam int TPS = 4;
  localparam int NV  = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_timer, irq_alarm;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_timer(irq_timer), .irq_alarm(irq_alarm)
  );

  // {yr,mo,dy,hr,mi,se} start, {yr,mo,dy,hr,mi,se} expected, status events
  localparam logic [103:0] VEC [NV] = '{
    {48'h00_01_01_00_00_00, 48'h00_01_01_00_00_01, 8'h04},
    {48'h00_01_01_00_00_59, 48'h00_01_01_00_01_00, 8'h0C},
    {48'h00_01_01_00_59_59, 48'h00_01_01_01_00_00, 8'h1C},
    {48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00, 8'h3C},
    {48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00, 8'h3C},
    {48'h24_02_29_23_59_59, 48'h24_03_01_00_00_00, 8'h3C},
    {48'h12_02_28_23_59_59, 48'h12_02_29_00_00_00, 8'h3C},
    {48'h10_02_28_23_59_59, 48'h10_03_01_00_00_00, 8'h3C},
    {48'h05_04_30_23_59_59, 48'h05_05_01_00_00_00, 8'h3C},
    {48'h05_11_30_23_59_59, 48'h05_12_01_00_00_00, 8'h3C},
    {48'h05_01_31_23_59_59, 48'h05_02_01_00_00_00, 8'h3C},
    {48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00, 8'h3C},
    {48'h07_06_15_09_19_59, 48'h07_06_15_09_20_00, 8'h0C},
    {48'h07_06_15_09_59_59, 48'h07_06_15_10_00_00, 8'h1C}
  };

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(8'(4 * i), t[8*i +: 8]);
  endtask

  task automatic set_alarm(input logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(8'(8'h20 + 4 * i), t[8*i +: 8]);
  endtask

  task automatic get_time(output logic [47:0] t);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin
      rd(8'(4 * i), b);
      t[8*i +: 8] = b;
    end
  endtask

  // enable run, let exactly n second steps happen, then stop
  task automatic run_secs(input int n);
    wr(8'h40, 8'h01);
    repeat (TPS * n + 1) @(negedge clk);
    wr(8'h40, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [47:0] t;
    logic [7:0]  b;
    int pulses;
    int busy_n;
    int run_n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    get_time(t);
    chk("R1 time", t, 48'h00_01_01_00_00_00);
    rd(8'h40, b); chk("R1 ctrl", b, 8'h00);
    rd(8'h44, b); chk("R1 status", b, 8'h00);
    rd(8'h48, b); chk("R1 ienable", b, 8'h00);
    chk("R1 irqs", {irq_timer, irq_alarm}, 2'b00);

    // R2 register map
    set_alarm(48'h31_08_17_22_45_33);
    for (int i = 0; i < 6; i++) begin
      rd(8'(8'h20 + 4 * i), b);
      t[8*i +: 8] = b;
    end
    chk("R2 alarm readback", t, 48'h31_08_17_22_45_33);
    rd(8'h3C, b); chk("R2 unmapped 0x3C", b, 8'h00);
    rd(8'h18, b); chk("R2 unmapped 0x18", b, 8'h00);
    set_alarm(48'h50_01_01_00_00_00);

    // R3 R4 R5 R7 R10 vector table
    for (int v = 0; v < NV; v++) begin
      set_time(VEC[v][103:56]);
      wr(8'h44, 8'h7C);
      run_secs(1);
      get_time(t);
      chk($sformatf("R3/R4/R5/R10 vector %0d time", v), t, VEC[v][55:8]);
      rd(8'h44, b);
      chk($sformatf("R7 vector %0d events", v), b & 8'h3C, VEC[v][7:0]);
    end

    // R6 stopped holds, run bit mirrored
    set_time(48'h01_03_04_05_06_07);
    repeat (20) @(negedge clk);
    get_time(t);
    chk("R6 stopped time", t, 48'h01_03_04_05_06_07);
    rd(8'h44, b); chk("R6 run bit off", b[1], 1'b0);

    // R11 busy once per second, R6 run bit on
    wr(8'h40, 8'h01);
    busy_n = 0; run_n = 0;
    for (int k = 0; k < 2 * TPS; k++) begin
      rd(8'h44, b);
      busy_n += b[0];
      run_n  += b[1];
    end
    wr(8'h40, 8'h00);
    chk("R11 busy count", busy_n, 2);
    chk("R6 run bit on", run_n, 2 * TPS);

    // R8 timer pulses and R3 rate
    set_time(48'h00_01_01_00_00_00);
    wr(8'h48, 8'h04);
    wr(8'h40, 8'h01);
    pulses = 0;
    for (int k = 0; k < 10 * TPS; k++) begin
      @(negedge clk);
      pulses += irq_timer;
    end
    wr(8'h40, 8'h00);
    chk("R8 timer pulses", pulses, 10);
    get_time(t);
    chk("R3 ten seconds", t, 48'h00_01_01_00_00_10);

    // R9 alarm mismatch in year only
    wr(8'h48, 8'h08);
    set_alarm(48'h01_01_01_00_00_00);
    set_time(48'h99_12_31_23_59_58);
    wr(8'h44, 8'h7C);
    run_secs(2);
    rd(8'h44, b);
    chk("R9 mismatch flag", b[6], 1'b0);
    chk("R9 mismatch irq", irq_alarm, 1'b0);

    // R9 full match with enable off
    wr(8'h48, 8'h00);
    set_alarm(48'h00_01_01_00_00_00);
    set_time(48'h99_12_31_23_59_58);
    run_secs(2);
    rd(8'h44, b);
    chk("R9 match flag", b[6], 1'b1);
    chk("R9 irq disabled", irq_alarm, 1'b0);
    wr(8'h48, 8'h08);
    @(negedge clk);
    chk("R9 irq enabled", irq_alarm, 1'b1);

    // R7 write-one-to-clear
    wr(8'h44, 8'h00);
    rd(8'h44, b);
    chk("R7 zero write keeps", b, 8'h7C);
    wr(8'h44, 8'h40);
    rd(8'h44, b);
    chk("R7 alarm cleared", b, 8'h3C);
    chk("R7 irq released", irq_alarm, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule